// File: doc/BRIEF.md
# Dual-Controller Interrupt Acknowledge Resolver

This block resolves interrupt acknowledge reads for a pair of interrupt controllers. Each controller owns a bank of sources. Every source carries a pending input, a mask bit, a 3-bit level, a 3-bit priority and an 8-bit vector number. A source counts as active when it is pending, unmasked and has a non-zero level.

A processor reads the block through a simple read port: a one-cycle strobe and an address. Two addresses give a per-controller software acknowledge. It returns the vector of that controller's best active source and records the winner's level and priority. Seven more addresses, one per level, return the best vector at that level across both controllers. When the two controllers tie, controller 0 wins.

Each controller's record of the last acknowledged level and priority is brought out as an output port. Read data is registered and appears on the cycle after the strobe.

Top module: `irq_ack_resolver`

## Requirements
- R1: A read strobe at address 0 (controller 0) or address 1 (controller 1) returns the vector of that controller's active source with the largest key {level, priority}, where level is the upper three bits of the key. Among sources with equal keys, the lowest source index wins.
- R2: A source is active only when its pending bit is 1, its mask bit is 0 and its level is non-zero. Masked sources, sources that are not pending and sources at level 0 never affect any read result or record.
- R3: A software acknowledge read of controller c loads that controller's record output with the 6-bit winner key: level in bits [5:3] and priority in bits [2:0].
- R4: A software acknowledge read of a controller with no active source returns 0 and clears that controller's record to 0.
- R5: A read at address 8+n, for n from 1 to 7, returns the vector of the highest-priority active source whose level is n, searched across both controllers. Within one controller, the lowest index wins ties.
- R6: In a level read, controller 0 wins when both controllers' best sources have equal priority. Controller 1 wins only when its best priority is strictly higher.
- R7: A level read with no active source at that level returns 0. Addresses 2 to 8 return 0, and no address gives a software acknowledge across both controllers.
- R8: Read data is valid on the first clock edge after the strobe and holds while no strobe is given, even if the source inputs change. A controller's record changes only on a software acknowledge read of that controller.
- R9: Reset (rstN low) clears the read data and both records to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdStrobe | input | 1 | One-cycle read request |
| rdAddr | input | 4 | Read address: 0/1 software acknowledge, 9..15 level 1..7 |
| srcPend | input | 16 | Pending bits; controller c source i at bit c*8+i |
| srcMask | input | 16 | Mask bits, 1 blocks the source |
| srcLevel | input | 48 | 3-bit levels, source k at [3k+2:3k] |
| srcPrio | input | 48 | 3-bit priorities, same packing as levels |
| srcVec | input | 128 | 8-bit vectors, source k at [8k+7:8k] |
| rdData | output | 8 | Registered acknowledge vector |
| ackRec0 | output | 6 | Controller 0 record {level, priority} |
| ackRec1 | output | 6 | Controller 1 record {level, priority} |

## Verification
The bench builds the block with its default parameters: eight sources per controller, 3-bit levels and priorities, and 8-bit vectors. All seven levels and all eight priorities are therefore in reach, and so are equal-key ties both inside a controller and across the two. Directed reads cover masking, level-0 sources, empty controllers, empty levels and unmapped addresses. A long run of random source settings and random addresses then stresses the arbitration against a bench model built from the requirements.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int LVL_W    = 3;
  localparam int PRI_W    = 3;
  localparam int KEY_W    = LVL_W + PRI_W;
  localparam int NUM_CTRL = 2;

  // strobes from the address decoder to the datapath
  typedef struct packed {
    logic             load;    // any read: capture read data
    logic             swRead;  // per-controller software acknowledge
    logic             swSel;   // which controller
    logic             lvlRead; // per-level acknowledge across controllers
    logic [LVL_W-1:0] lvlSel;  // level being read
  } ackStrobe_t;
endpackage

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_ack_pkg::*;
(
  input  logic           rdStrobe,
  input  logic [LVL_W:0] rdAddr,
  output ackStrobe_t     strobe
);
  always_comb begin
    strobe        = '0;
    strobe.lvlSel = rdAddr[LVL_W-1:0];
    if (rdStrobe) begin
      strobe.load = 1'b1;
      if (rdAddr[LVL_W]) begin
        strobe.lvlRead = (rdAddr[LVL_W-1:0] != '0);
      end else if (rdAddr[LVL_W-1:1] == '0) begin
        strobe.swRead = 1'b1;
        strobe.swSel  = rdAddr[0];
      end
    end
  end
endmodule

// File: rtl/irq_ack_arb.sv
module irq_ack_arb
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC-1:0]       mask,
  input  logic [NUM_SRC*LVL_W-1:0] level,
  input  logic [NUM_SRC*PRI_W-1:0] prio,
  input  logic [NUM_SRC*VEC_W-1:0] vec,
  input  logic                     filtEn,
  input  logic [LVL_W-1:0]         filtLvl,
  output logic                     found,
  output logic [KEY_W-1:0]         bestKey,
  output logic [VEC_W-1:0]         bestVec
);
  logic [NUM_SRC-1:0] cand;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      cand[i] = pend[i] && !mask[i] && (level[i*LVL_W +: LVL_W] != '0) &&
                (!filtEn || (level[i*LVL_W +: LVL_W] == filtLvl));
    end
  end

  // strict compare keeps the lowest index on equal keys
  always_comb begin
    found   = 1'b0;
    bestKey = '0;
    bestVec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!found ||
          {level[i*LVL_W +: LVL_W], prio[i*PRI_W +: PRI_W]} > bestKey)) begin
        found   = 1'b1;
        bestKey = {level[i*LVL_W +: LVL_W], prio[i*PRI_W +: PRI_W]};
        bestVec = vec[i*VEC_W +: VEC_W];
      end
    end
  end
endmodule

// File: rtl/irq_ack_dp.sv
module irq_ack_dp
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ackStrobe_t                          strobe,
  input  logic [NUM_CTRL*NUM_SRC-1:0]         srcPend,
  input  logic [NUM_CTRL*NUM_SRC-1:0]         srcMask,
  input  logic [NUM_CTRL*NUM_SRC*LVL_W-1:0]   srcLevel,
  input  logic [NUM_CTRL*NUM_SRC*PRI_W-1:0]   srcPrio,
  input  logic [NUM_CTRL*NUM_SRC*VEC_W-1:0]   srcVec,
  output logic [VEC_W-1:0]                    rdData,
  output logic [NUM_CTRL*KEY_W-1:0]           recFlat
);
  logic [NUM_CTRL-1:0] found;
  logic [KEY_W-1:0]    key [NUM_CTRL];
  logic [VEC_W-1:0]    vec [NUM_CTRL];
  logic [VEC_W-1:0]    nextData;

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
    irq_ack_arb #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
      .pend    (srcPend [c*NUM_SRC       +: NUM_SRC]),
      .mask    (srcMask [c*NUM_SRC       +: NUM_SRC]),
      .level   (srcLevel[c*NUM_SRC*LVL_W +: NUM_SRC*LVL_W]),
      .prio    (srcPrio [c*NUM_SRC*PRI_W +: NUM_SRC*PRI_W]),
      .vec     (srcVec  [c*NUM_SRC*VEC_W +: NUM_SRC*VEC_W]),
      .filtEn  (strobe.lvlRead),
      .filtLvl (strobe.lvlSel),
      .found   (found[c]),
      .bestKey (key[c]),
      .bestVec (vec[c])
    );
  end

  always_comb begin
    nextData = '0;
    if (strobe.swRead) begin
      nextData = found[strobe.swSel] ? vec[strobe.swSel] : '0;
    end else if (strobe.lvlRead) begin
      // controller 1 takes over only with a strictly larger key
      if (found[1] && (!found[0] || key[1] > key[0])) nextData = vec[1];
      else if (found[0])                               nextData = vec[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      recFlat <= '0;
    end else begin
      if (strobe.load) rdData <= nextData;
      for (int c = 0; c < NUM_CTRL; c++) begin
        if (strobe.swRead && (int'(strobe.swSel) == c)) begin
          recFlat[c*KEY_W +: KEY_W] <= found[c] ? key[c] : '0;
        end
      end
    end
  end
endmodule

// File: rtl/irq_ack_resolver.sv
module irq_ack_resolver
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              rdStrobe,
  input  logic [LVL_W:0]                    rdAddr,
  input  logic [NUM_CTRL*NUM_SRC-1:0]       srcPend,
  input  logic [NUM_CTRL*NUM_SRC-1:0]       srcMask,
  input  logic [NUM_CTRL*NUM_SRC*LVL_W-1:0] srcLevel,
  input  logic [NUM_CTRL*NUM_SRC*PRI_W-1:0] srcPrio,
  input  logic [NUM_CTRL*NUM_SRC*VEC_W-1:0] srcVec,
  output logic [VEC_W-1:0]                  rdData,
  output logic [KEY_W-1:0]                  ackRec0,
  output logic [KEY_W-1:0]                  ackRec1
);
  ackStrobe_t                strobe;
  logic [NUM_CTRL*KEY_W-1:0] recFlat;

  irq_ack_ctrl u_ctrl (
    .rdStrobe (rdStrobe),
    .rdAddr   (rdAddr),
    .strobe   (strobe)
  );

  irq_ack_dp #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .srcPend  (srcPend),
    .srcMask  (srcMask),
    .srcLevel (srcLevel),
    .srcPrio  (srcPrio),
    .srcVec   (srcVec),
    .rdData   (rdData),
    .recFlat  (recFlat)
  );

  assign ackRec0 = recFlat[0     +: KEY_W];
  assign ackRec1 = recFlat[KEY_W +: KEY_W];
endmodule

// File: rtl/irq_ack_resolver_chk.sv
module irq_ack_resolver_chk
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 8
) (
  input logic                              clk,
  input logic                              rstN,
  input logic                              rdStrobe,
  input logic [LVL_W:0]                    rdAddr,
  input logic [NUM_CTRL*NUM_SRC-1:0]       srcPend,
  input logic [NUM_CTRL*NUM_SRC-1:0]       srcMask,
  input logic [NUM_CTRL*NUM_SRC*LVL_W-1:0] srcLevel,
  input logic [VEC_W-1:0]                  rdData,
  input logic [KEY_W-1:0]                  ackRec0,
  input logic [KEY_W-1:0]                  ackRec1
);
  logic [NUM_CTRL*NUM_SRC-1:0] live;
  logic                        any0, any1, sw0, sw1, unmapped;

  always_comb begin
    for (int k = 0; k < NUM_CTRL*NUM_SRC; k++) begin
      live[k] = srcPend[k] && !srcMask[k] && (srcLevel[k*LVL_W +: LVL_W] != '0);
    end
  end

  assign any0     = |live[0       +: NUM_SRC];
  assign any1     = |live[NUM_SRC +: NUM_SRC];
  assign sw0      = rdStrobe && (rdAddr == 0);
  assign sw1      = rdStrobe && (rdAddr == 1);
  assign unmapped = rdStrobe && (rdAddr >= 2) && (rdAddr <= 8);

  AST_DATA_HOLD:    assert property (@(posedge clk) disable iff (!rstN) !rdStrobe |=> $stable(rdData)); // R8
  AST_REC0_HOLD:    assert property (@(posedge clk) disable iff (!rstN) !sw0 |=> $stable(ackRec0)); // R8
  AST_REC1_HOLD:    assert property (@(posedge clk) disable iff (!rstN) !sw1 |=> $stable(ackRec1)); // R8
  AST_EMPTY0_ZERO:  assert property (@(posedge clk) disable iff (!rstN) (sw0 && !any0) |=> (rdData == '0 && ackRec0 == '0)); // R4
  AST_EMPTY1_ZERO:  assert property (@(posedge clk) disable iff (!rstN) (sw1 && !any1) |=> (rdData == '0 && ackRec1 == '0)); // R4
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN) unmapped |=> rdData == '0); // R7
  AST_REC0_LEVEL:   assert property (@(posedge clk) disable iff (!rstN) (sw0 && any0) |=> ackRec0[KEY_W-1 -: LVL_W] != '0); // R3
  AST_REC1_LEVEL:   assert property (@(posedge clk) disable iff (!rstN) (sw1 && any1) |=> ackRec1[KEY_W-1 -: LVL_W] != '0); // R3
endmodule

bind irq_ack_resolver irq_ack_resolver_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdStrobe (rdStrobe),
  .rdAddr   (rdAddr),
  .srcPend  (srcPend),
  .srcMask  (srcMask),
  .srcLevel (srcLevel),
  .rdData   (rdData),
  .ackRec0  (ackRec0),
  .ackRec1  (ackRec1)
);

// File: tb/irq_ack_resolver_bench.sv
module irq_ack_resolver_bench;
  localparam int NS = 8;
  localparam int VW = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            rdStrobe = 1'b0;
  logic [3:0]      rdAddr = '0;
  logic [2*NS-1:0]    srcPend, srcMask;
  logic [2*NS*3-1:0]  srcLevel, srcPrio;
  logic [2*NS*VW-1:0] srcVec;
  logic [VW-1:0]   rdData;
  logic [5:0]      ackRec0, ackRec1;

  bit       pend [2][NS];
  bit       mask [2][NS];
  bit [2:0] lvl  [2][NS];
  bit [2:0] pri  [2][NS];
  bit [7:0] vec  [2][NS];

  typedef struct { int data; int r0; int r1; string tag; } exp_t;
  exp_t q[$];
  exp_t e;
  int   expRec0 = 0, expRec1 = 0, lastData = 0;
  int   nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < NS; i++) begin
        srcPend[c*NS+i]             = pend[c][i];
        srcMask[c*NS+i]             = mask[c][i];
        srcLevel[(c*NS+i)*3 +: 3]   = lvl[c][i];
        srcPrio[(c*NS+i)*3 +: 3]    = pri[c][i];
        srcVec[(c*NS+i)*VW +: VW]   = vec[c][i];
      end
    end
  end

  irq_ack_resolver #(.NUM_SRC(NS), .VEC_W(VW)) u_irq_ack_resolver (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .srcPend(srcPend), .srcMask(srcMask), .srcLevel(srcLevel),
    .srcPrio(srcPrio), .srcVec(srcVec), .rdData(rdData),
    .ackRec0(ackRec0), .ackRec1(ackRec1)
  );

  // reference model written from the requirements
  function automatic void best(input int c, input bit fe, input int fl,
                               output bit f, output int k, output int v);
    f = 0; k = 0; v = 0;
    for (int i = 0; i < NS; i++) begin
      if (pend[c][i] && !mask[c][i] && lvl[c][i] != 0 && (!fe || lvl[c][i] == fl)) begin
        if (!f || (lvl[c][i]*8 + pri[c][i]) > k) begin
          f = 1; k = lvl[c][i]*8 + pri[c][i]; v = vec[c][i];
        end
      end
    end
  endfunction

  task automatic setSrc(input int c, input int i, input bit p, input bit m,
                        input int l, input int pr, input int v);
    pend[c][i] = p; mask[c][i] = m; lvl[c][i] = 3'(l); pri[c][i] = 3'(pr); vec[c][i] = 8'(v);
  endtask

  task automatic clearCtrl(input int c);
    for (int i = 0; i < NS; i++) setSrc(c, i, 0, 0, 0, 0, 0);
  endtask

  // driver: computes the expected result and queues it
  task automatic doRead(input int a, input string tag);
    bit f0, f1; int k0, k1, v0, v1; exp_t x;
    @(negedge clk);
    x.data = 0;
    if (a == 0 || a == 1) begin
      best(a, 0, 0, f0, k0, v0);
      x.data = f0 ? v0 : 0;
      if (a == 0) expRec0 = f0 ? k0 : 0; else expRec1 = f0 ? k0 : 0;
    end else if (a >= 9) begin
      best(0, 1, a-8, f0, k0, v0);
      best(1, 1, a-8, f1, k1, v1);
      if (f1 && (!f0 || k1 > k0)) x.data = v1;
      else if (f0)                x.data = v0;
    end
    x.r0 = expRec0; x.r1 = expRec1; x.tag = tag;
    lastData = x.data;
    rdAddr = 4'(a); rdStrobe = 1'b1;
    q.push_back(x);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic checkNow(input string tag, input int d, input int r0, input int r1);
    nChecks++;
    if (rdData !== 8'(d) || ackRec0 !== 6'(r0) || ackRec1 !== 6'(r1)) begin
      nFails++;
      $display("FAIL %s: data=%0h rec0=%0d rec1=%0d expected data=%0h rec0=%0d rec1=%0d",
               tag, rdData, ackRec0, ackRec1, d, r0, r1);
    end
  endtask

  // monitor: result is registered on the edge after the strobe
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checkNow(e.tag, e.data, e.r0, e.r1);
      end
    end
  end

  initial begin
    #(200000 * 10);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    clearCtrl(0); clearCtrl(1);
    repeat (3) @(negedge clk);
    checkNow("R9 reset state", 0, 0, 0);
    rstN = 1'b1;

    setSrc(0, 2, 1, 0, 3, 5, 8'h23);
    setSrc(0, 5, 1, 0, 6, 1, 8'h56);
    setSrc(0, 7, 1, 0, 4, 7, 8'h47);
    doRead(0, "R1 R3 highest level wins");
    setSrc(0, 1, 1, 0, 6, 4, 8'h61);
    doRead(0, "R1 priority within level");
    setSrc(0, 6, 1, 0, 6, 4, 8'h66);
    doRead(0, "R1 equal key lowest index");
    mask[0][1] = 1;
    setSrc(0, 0, 1, 0, 0, 7, 8'h0F);
    setSrc(0, 3, 0, 0, 7, 7, 8'h73);
    doRead(0, "R2 masked level0 idle ignored");
    setSrc(1, 4, 1, 0, 2, 2, 8'h92);
    doRead(1, "R1 R3 controller 1 software ack");
    clearCtrl(1);
    doRead(1, "R4 empty controller clears record");
    doRead(14, "R5 level 6 read");
    doRead(11, "R5 level 3 read");
    doRead(12, "R5 level 4 read");
    setSrc(1, 0, 1, 0, 3, 5, 8'hA3);
    doRead(11, "R6 tie goes to controller 0");
    setSrc(1, 1, 1, 0, 3, 6, 8'hB3);
    doRead(11, "R6 controller 1 higher priority");
    @(negedge clk);
    setSrc(1, 1, 0, 0, 0, 0, 0);
    setSrc(0, 5, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    checkNow("R8 data and records hold without strobe", lastData, expRec0, expRec1);
    doRead(13, "R7 empty level 5");
    doRead(12, "R5 level 4 again");
    doRead(15, "R7 level 7 source not pending");
    doRead(12, "R5 level 4 again");
    doRead(2, "R7 unmapped address 2");
    doRead(12, "R5 level 4 again");
    doRead(8, "R7 unmapped address 8");
    clearCtrl(0);
    doRead(0, "R4 controller 0 emptied");

    for (int n = 0; n < 400; n++) begin
      if (n % 8 == 0) begin
        for (int c = 0; c < 2; c++)
          for (int i = 0; i < NS; i++)
            setSrc(c, i, ($urandom % 3) != 0, ($urandom % 4) == 0,
                   $urandom % 8, $urandom % 4, $urandom % 256);
      end
      doRead($urandom % 16, "R1 R5 R6 random read");
    end

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule